// File: doc/BRIEF.md
# Zero-Padded Streaming 3x3 Convolver

This block filters a raster-scanned greyscale frame with a programmable 3x3 signed kernel and produces one signed result for every pixel position, so the result frame has the same width and height as the input. Pixels are unsigned and arrive one per accepted handshake, row by row and left to right. Only two earlier rows are held on chip, in two line stores. Neighbours that fall outside the frame on any of the four sides count as zero.

Internally, the block steps through a grid of slots that is one column wider and one row taller than the frame. The extra column supplies the right-hand zero padding. The extra row flushes the last results out after the final pixel, with no further input. Each slot shifts one new column of three taps into a 3x3 window register. A two-stage multiply-add then turns the window into a result.

Pixel input uses a valid/ready handshake. A pixel is taken on a rising edge where `px_valid` and `px_ready` are both high. `px_ready` falls for one cycle after the last pixel of each row. After the last pixel of the frame it stays low until the flush is over. `px_valid` may drop at any time, and the block then simply waits. The result output has no ready: each result is present for exactly one cycle and the consumer must take it. The kernel is written one coefficient at a time. A write is only taken while no frame is in flight.

Top module: `conv3x3_pad_stream`

## Requirements
- R1: After a synchronous active-high reset, `res_valid` is 0 and `px_ready` is 1. No result appears while no pixel is offered.
- R2: Each frame of IMG_W*IMG_H accepted pixels yields exactly IMG_W*IMG_H results. The results come out in raster order of their centre positions.
- R3: A result is the sum over the nine taps of pixel times coefficient. The pixel is an unsigned value zero-extended before the multiply, and the coefficient is two's complement. The 20-bit signed result holds the extreme sums exactly: all pixels 255 with all coefficients -128 or all +127.
- R4: Every tap whose row is -1 or IMG_H, or whose column is -1 or IMG_W, contributes zero. Data left over from an earlier frame never leaks into a later one.
- R5: Each frame has exactly IMG_H+IMG_W+1 cycles with `px_ready` low. There is one cycle after each row's last pixel, and IMG_W+1 more cycles of flush after the final one.
- R6: Cycles with `px_valid` low do not change any result value or the result order.
- R7: The first result of a frame becomes visible on the second rising edge after the edge that accepts the pixel at row 1, column 1.
- R8: Coefficient index k (0..8) selects the tap at row offset k/3-1 and column offset k%3-1, in row-major order. Writes with an index of 9..15 are ignored. Writes made while a frame is in flight are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| px_valid | input | 1 | Pixel offered |
| px_ready | output | 1 | Pixel can be taken this cycle |
| px_data | input | PIX_W | Unsigned pixel value |
| k_wr | input | 1 | Coefficient write strobe |
| k_sel | input | 4 | Coefficient index, row-major 0..8 |
| k_val | input | COEF_W | Signed coefficient value |
| res_valid | output | 1 | Result present this cycle |
| res_data | output | PIX_W+COEF_W+4 | Signed convolution result |

## Verification
Several properties are checked on every cycle. A result appears exactly two cycles after its window is complete. A window forms only on a slot step. The coefficients stay stable while results are coming out or while writes are locked out. A right-padding stall is always followed by a ready cycle. Every result stays inside the arithmetic bound. Other behaviour only shows up in whole-frame scenarios with a reference convolution in the bench. This covers the tap orientation and all four borders, which need an asymmetric kernel to tell apart. It also covers leftover line data across frames, immunity to input gaps, the total stall count, and writes ignored by index or by timing.

// File: rtl/conv_pkg.sv
package conv_pkg;
  localparam int TAPS   = 9;
  localparam int KSEL_W = 4;
  localparam int KDIM   = 3;
endpackage

// File: rtl/cnv_slot_seq.sv
module cnv_slot_seq #(
  parameter int IMG_W = 128,
  parameter int IMG_H = 128,
  localparam int RW = $clog2(IMG_H + 1),
  localparam int CW = $clog2(IMG_W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          px_valid,
  output logic          px_ready,
  output logic          step,
  output logic          emit,
  output logic          idle,
  output logic          row_top,
  output logic          row_top2,
  output logic          flush_row,
  output logic          pad_col,
  output logic [CW-1:0] col
);
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic          live_slot;

  assign live_slot = (row_q < RW'(IMG_H)) && (col_q < CW'(IMG_W));
  assign px_ready  = live_slot;
  assign step      = live_slot ? px_valid : 1'b1;
  assign emit      = step && (row_q != '0) && (col_q != '0);
  assign idle      = (row_q == '0) && (col_q == '0);
  assign row_top   = (row_q == '0);
  assign row_top2  = (row_q <= RW'(1));
  assign flush_row = (row_q == RW'(IMG_H));
  assign pad_col   = (col_q == CW'(IMG_W));
  assign col       = col_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
      col_q <= '0;
    end else if (step) begin
      if (pad_col) begin
        col_q <= '0;
        row_q <= flush_row ? '0 : row_q + RW'(1);
      end else begin
        col_q <= col_q + CW'(1);
      end
    end
  end

  // a right-pad stall inside the frame lasts exactly one cycle
  assert_stall_one_R5: assert property (@(posedge clk) disable iff (rst)
    (pad_col && (row_q < RW'(IMG_H - 1))) |=> px_ready);
endmodule

// File: rtl/cnv_line_win.sv
module cnv_line_win
  import conv_pkg::*;
#(
  parameter int IMG_W = 128,
  parameter int PIX_W = 8,
  localparam int CW = $clog2(IMG_W + 1),
  localparam int AW = $clog2(IMG_W)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       step,
  input  logic                       emit,
  input  logic                       row_top,
  input  logic                       row_top2,
  input  logic                       flush_row,
  input  logic                       pad_col,
  input  logic [CW-1:0]              col,
  input  logic [PIX_W-1:0]           pix,
  output logic [TAPS-1:0][PIX_W-1:0] taps,
  output logic                       win_vld
);
  logic [PIX_W-1:0] lb_near [IMG_W];
  logic [PIX_W-1:0] lb_far  [IMG_W];
  logic [PIX_W-1:0] win_q   [KDIM][KDIM];
  logic [AW-1:0]    addr;
  logic [PIX_W-1:0] near_rd, far_rd;
  logic [PIX_W-1:0] col_bot, col_mid, col_top;

  assign addr    = pad_col ? '0 : col[AW-1:0];
  assign near_rd = lb_near[addr];
  assign far_rd  = lb_far[addr];

  // masking of out-of-frame taps at entry into the window
  assign col_bot = (flush_row || pad_col) ? '0 : pix;
  assign col_mid = (pad_col || row_top)   ? '0 : near_rd;
  assign col_top = (pad_col || row_top2)  ? '0 : far_rd;

  always_ff @(posedge clk) begin
    if (step && !pad_col) begin
      lb_near[addr] <= col_bot;
      lb_far[addr]  <= near_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (step) begin
      for (int rr = 0; rr < KDIM; rr++) begin
        win_q[rr][0] <= win_q[rr][1];
        win_q[rr][1] <= win_q[rr][2];
      end
      win_q[0][2] <= col_top;
      win_q[1][2] <= col_mid;
      win_q[2][2] <= col_bot;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) win_vld <= 1'b0;
    else     win_vld <= emit;
  end

  for (genvar rr = 0; rr < KDIM; rr++) begin : g_row
    for (genvar cc = 0; cc < KDIM; cc++) begin : g_col
      assign taps[rr*KDIM+cc] = win_q[rr][cc];
    end
  end

  assert_win_step_R7: assert property (@(posedge clk) disable iff (rst)
    win_vld |-> $past(step));

  assert_top_pad_R4: assert property (@(posedge clk) disable iff (rst)
    (step && row_top) |=> (win_q[0][2] == '0 && win_q[1][2] == '0));
endmodule

// File: rtl/cnv_coef_bank.sv
module cnv_coef_bank
  import conv_pkg::*;
#(
  parameter int COEF_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load_en,
  input  logic                        wr,
  input  logic [KSEL_W-1:0]           sel,
  input  logic [COEF_W-1:0]           val,
  output logic [TAPS-1:0][COEF_W-1:0] coefs
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) coefs[i] <= '0;
      else if (load_en && wr && (sel == KSEL_W'(i))) coefs[i] <= val;
    end
  end

  assert_coef_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(load_en && wr) |=> $stable(coefs));
endmodule

// File: rtl/cnv_mac9.sv
module cnv_mac9
  import conv_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  localparam int PROD_W = PIX_W + COEF_W,
  localparam int ACC_W  = PIX_W + COEF_W + 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        win_vld,
  input  logic [TAPS-1:0][PIX_W-1:0]  taps,
  input  logic [TAPS-1:0][COEF_W-1:0] coefs,
  output logic                        busy,
  output logic                        res_vld,
  output logic signed [ACC_W-1:0]     res
);
  localparam longint PMAX = (longint'(1) << PIX_W) - 1;
  localparam longint CMAG = longint'(1) << (COEF_W - 1);
  localparam longint BND  = TAPS * PMAX * CMAG;

  logic signed [PROD_W-1:0] prod_q [TAPS];
  logic                     prod_vld;
  logic signed [ACC_W-1:0]  acc;

  for (genvar i = 0; i < TAPS; i++) begin : g_mul
    always_ff @(posedge clk) begin
      if (win_vld)
        prod_q[i] <= $signed({1'b0, taps[i]}) * $signed(coefs[i]);
    end
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < TAPS; i++) acc = acc + ACC_W'(prod_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_vld <= 1'b0;
      res_vld  <= 1'b0;
    end else begin
      prod_vld <= win_vld;
      res_vld  <= prod_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (prod_vld) res <= acc;
  end

  assign busy = prod_vld;

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> $past(win_vld, 2));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> (longint'(res) >= -BND && longint'(res) <= BND));
endmodule

// File: rtl/conv3x3_pad_stream.sv
module conv3x3_pad_stream
  import conv_pkg::*;
#(
  parameter int IMG_W  = 128,
  parameter int IMG_H  = 128,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  localparam int ACC_W = PIX_W + COEF_W + 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    px_valid,
  output logic                    px_ready,
  input  logic [PIX_W-1:0]        px_data,
  input  logic                    k_wr,
  input  logic [KSEL_W-1:0]       k_sel,
  input  logic [COEF_W-1:0]       k_val,
  output logic                    res_valid,
  output logic signed [ACC_W-1:0] res_data
);
  localparam int CW = $clog2(IMG_W + 1);

  logic step, emit, idle, row_top, row_top2, flush_row, pad_col;
  logic [CW-1:0] col;
  logic [TAPS-1:0][PIX_W-1:0]  taps;
  logic [TAPS-1:0][COEF_W-1:0] coefs;
  logic win_vld, mac_busy, load_en;

  cnv_slot_seq #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_seq (
    .clk(clk), .rst(rst), .px_valid(px_valid), .px_ready(px_ready),
    .step(step), .emit(emit), .idle(idle), .row_top(row_top),
    .row_top2(row_top2), .flush_row(flush_row), .pad_col(pad_col), .col(col)
  );

  cnv_line_win #(.IMG_W(IMG_W), .PIX_W(PIX_W)) u_win (
    .clk(clk), .rst(rst), .step(step), .emit(emit), .row_top(row_top),
    .row_top2(row_top2), .flush_row(flush_row), .pad_col(pad_col),
    .col(col), .pix(px_data), .taps(taps), .win_vld(win_vld)
  );

  // coefficients only change when nothing is in flight
  assign load_en = idle && !win_vld && !mac_busy;

  cnv_coef_bank #(.COEF_W(COEF_W)) u_coef (
    .clk(clk), .rst(rst), .load_en(load_en), .wr(k_wr), .sel(k_sel),
    .val(k_val), .coefs(coefs)
  );

  cnv_mac9 #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_mac (
    .clk(clk), .rst(rst), .win_vld(win_vld), .taps(taps), .coefs(coefs),
    .busy(mac_busy), .res_vld(res_valid), .res(res_data)
  );

  assert_coef_steady_R8: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $stable(coefs));
endmodule

// File: tb/test_conv3x3_pad_stream.sv
module test_conv3x3_pad_stream;
  localparam int W = 7;
  localparam int H = 5;
  localparam int N = W * H;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic px_valid = 1'b0;
  logic px_ready;
  logic [7:0] px_data = '0;
  logic k_wr = 1'b0;
  logic [3:0] k_sel = '0;
  logic [7:0] k_val = '0;
  logic res_valid;
  logic signed [19:0] res_data;

  always #10 clk = ~clk;

  conv3x3_pad_stream #(.IMG_W(W), .IMG_H(H)) i_conv3x3_pad_stream (
    .clk(clk), .rst(rst), .px_valid(px_valid), .px_ready(px_ready),
    .px_data(px_data), .k_wr(k_wr), .k_sel(k_sel), .k_val(k_val),
    .res_valid(res_valid), .res_data(res_data)
  );

  int total = 0, bad = 0;
  int kern[9];
  int pix[N];
  int expv[N];
  int out_idx = 0, low_cnt = 0, acc_n = 0;
  int edge_cnt = 0, acc_edge = 0, first_edge = 0;
  string cur_tag = "R2";

  task automatic chk(input bit ok, input string tag, input int act,
                     input int exp_v, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp_v);
    end
  endtask

  always @(posedge clk) begin
    edge_cnt++;
    if (!rst) begin
      if (!px_ready) low_cnt++;
      if (px_valid && px_ready) begin
        if (acc_n == W + 1) acc_edge = edge_cnt;
        acc_n++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (out_idx == 0) first_edge = edge_cnt;
      if (out_idx < N)
        chk(int'(res_data) == expv[out_idx], cur_tag, int'(res_data),
            expv[out_idx], $sformatf("result %0d", out_idx));
      else
        chk(1'b0, "R2", out_idx, N - 1, "extra result");
      out_idx++;
    end
  end

  function automatic void compute_ref();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        int s = 0;
        for (int dr = -1; dr <= 1; dr++)
          for (int dc = -1; dc <= 1; dc++)
            if (r + dr >= 0 && r + dr < H && c + dc >= 0 && c + dc < W)
              s += pix[(r + dr) * W + c + dc] * kern[(dr + 1) * 3 + dc + 1];
        expv[r * W + c] = s;
      end
  endfunction

  task automatic load_kernel();
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      k_wr = 1'b1; k_sel = 4'(i); k_val = 8'(kern[i]);
    end
    // indices past the last tap must not alias onto any tap (R8)
    @(negedge clk); k_wr = 1'b1; k_sel = 4'd9;  k_val = 8'd77;
    @(negedge clk); k_wr = 1'b1; k_sel = 4'd12; k_val = 8'd91;
    @(negedge clk); k_wr = 1'b0;
  endtask

  task automatic send_frame(input bit gaps, input bit poke);
    for (int i = 0; i < N; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk); px_valid = 1'b0; k_wr = 1'b0;
      end
      @(negedge clk);
      px_valid = 1'b1; px_data = 8'(pix[i]);
      if (poke && i == 10) begin
        k_wr = 1'b1; k_sel = 4'd4; k_val = 8'd55;
      end else k_wr = 1'b0;
      while (!px_ready) begin
        @(negedge clk); k_wr = 1'b0;
      end
    end
    @(negedge clk); px_valid = 1'b0; k_wr = 1'b0;
  endtask

  task automatic run_frame(input string tag, input bit gaps, input bit poke);
    load_kernel();
    compute_ref();
    cur_tag = tag; out_idx = 0; low_cnt = 0; acc_n = 0;
    send_frame(gaps, poke);
    repeat (W + 12) @(negedge clk);
    chk(out_idx == N, "R2", out_idx, N, {"result count ", tag});
    chk(low_cnt == H + W + 1, "R5", low_cnt, H + W + 1, {"ready-low cycles ", tag});
    chk(first_edge - acc_edge == 2, "R7", first_edge - acc_edge, 2, {"first latency ", tag});
  endtask

  function automatic void fill_pix(input int seed);
    for (int i = 0; i < N; i++) pix[i] = (i * 53 + seed * 29 + (i * i) % 17) % 256;
  endfunction

  function automatic void set_kern(input int a0, a1, a2, a3, a4, a5, a6, a7, a8);
    kern[0] = a0; kern[1] = a1; kern[2] = a2; kern[3] = a3; kern[4] = a4;
    kern[5] = a5; kern[6] = a6; kern[7] = a7; kern[8] = a8;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b0, "R1", int'(res_valid), 0, "res_valid after reset");
    chk(px_ready == 1'b1, "R1", int'(px_ready), 1, "px_ready after reset");
    repeat (8) @(negedge clk);
    chk(out_idx == 0, "R1", out_idx, 0, "no result without input");

    // R2: identity kernel passes pixels through in raster order
    set_kern(0, 0, 0, 0, 1, 0, 0, 0, 0); fill_pix(0);
    run_frame("R2", 1'b0, 1'b0);
    // R6: box kernel with input gaps
    set_kern(1, 1, 1, 1, 1, 1, 1, 1, 1); fill_pix(1);
    run_frame("R6", 1'b1, 1'b0);
    // R8: write to centre tap mid-frame must be ignored
    set_kern(-1, -1, -1, -1, 8, -1, -1, -1, -1); fill_pix(2);
    run_frame("R8", 1'b0, 1'b1);
    // R4: asymmetric kernel exposes orientation and each border
    set_kern(1, -2, 3, -4, 5, -6, 7, -8, 9); fill_pix(3);
    run_frame("R4", 1'b1, 1'b0);
    // R3: extreme negative and positive sums
    set_kern(-128, -128, -128, -128, -128, -128, -128, -128, -128);
    for (int i = 0; i < N; i++) pix[i] = 255;
    run_frame("R3", 1'b0, 1'b0);
    set_kern(127, 127, 127, 127, 127, 127, 127, 127, 127);
    run_frame("R3", 1'b0, 1'b0);
    // R4: small values after a saturated frame show no stale line data
    set_kern(2, 3, -5, 7, -1, 4, -3, 6, 1); fill_pix(4);
    run_frame("R4", 1'b0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule